// File: doc/BRIEF.md
# Hamming Check-Bit Generator with Scannable Parity Flag

This block computes four modified-Hamming check bits and the full parity of one 8-bit data byte. All of these outputs are combinational. It also forms a gated parity result. The word parity can be inverted by an odd/even select and is then compared against an externally supplied expected parity bit, so the gated result is 1 when the two disagree.

The gated result feeds a one-bit clocked register, which drives an error flag in true and complement form. When enabled, the register can hold its value, capture the gated parity, or take a serial scan bit. The flag itself is the scan output, so several copies of the block can be joined into a serial scan ring. To do this, wire each instance's true flag to the next one's scan input. Check bits from several bytes can be combined externally to build a wider single-error-correct, double-error-detect scheme.

Top module: `hamming_parity_scan`

## Requirements
- R1: Check bits are XOR groups of the data byte: chk_o[0] covers bits 1,3,5,7; chk_o[1] covers bits 2,3,6,7; chk_o[2] covers bits 4,5,6,7; chk_o[3] covers bits 1,2,4,7.
- R2: word_par_o is the XOR of all eight data bits.
- R3: gen_par_o equals word_par_o XOR odd_sel_i XOR exp_par_i. odd_sel_i = 1 selects odd parity and inverts the word parity. gen_par_o = 1 flags a mismatch.
- R4: At a rising clock edge with rst_n low, the register clears to 0, giving err_o = 0 and err_n_o = 1.
- R5: At a rising edge with en_i = 1 and hold_i = 1, the register keeps its value, whatever shift_i and scan_i are.
- R6: At a rising edge with en_i = 1, hold_i = 0 and shift_i = 1, the register loads scan_i.
- R7: At a rising edge with en_i = 1, hold_i = 0 and shift_i = 0, the register loads gen_par_o.
- R8: At a rising edge with en_i = 0, the register keeps its value, whatever hold_i, shift_i, scan_i and the data are.
- R9: err_n_o is always the complement of err_o. err_o is the scan output, so instances chained err_o to scan_i shift one bit position per enabled shift edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the parity register |
| rst_n | input | 1 | Synchronous active-low reset |
| data_i | input | 8 | Data byte |
| odd_sel_i | input | 1 | 1 selects odd parity (inverts word parity) |
| exp_par_i | input | 1 | Expected parity bit XORed into the gated result |
| en_i | input | 1 | Register clock enable |
| hold_i | input | 1 | Keep register value (priority over shift) |
| shift_i | input | 1 | 1 loads scan_i, 0 loads gated parity |
| scan_i | input | 1 | Serial scan input |
| chk_o | output | 4 | Modified-Hamming check bits |
| word_par_o | output | 1 | Parity of the whole byte |
| gen_par_o | output | 1 | Gated odd/even parity result |
| err_o | output | 1 | Registered error flag and scan output |
| err_n_o | output | 1 | Complement of err_o |

## Verification
Assertions check the register's next-state rules at every clock edge: reset clearing, hold and disable keeping the value, shift taking the scan bit, and load taking the gated parity. The check-bit groups, the word parity and the odd/even gating are combinational mappings, so only the bench can show them. It sweeps all 256 bytes under every polarity and expected-bit setting. Propagation along a serial ring of three instances is also a scenario-only property, because each instance sees only its own neighbour.

// File: rtl/hps_pkg.sv
// Package: shared sizing and check-group mask computation for the
// Hamming parity block. Assumes a byte-wide data word split into
// three binary-weighted groups plus one odd-weight group.
package hps_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int CHK_W  = IDX_W + 1;

    // Returns the data-bit mask for check group g. Groups below IDX_W
    // select bits whose index has bit g set. The last group selects
    // bits whose index has an odd number of ones.
    function automatic logic [DATA_W-1:0] group_mask(input int g);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int b = 0; b < DATA_W; b++) begin
            if (g < IDX_W) begin
                m[b] = ((b >> g) & 1) == 1;
            end else begin
                m[b] = ($countones(b) % 2) == 1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/hps_check_gen.sv
// Module: hps_check_gen
// Forms the check bits and the whole-word parity from the data byte.
// Purely combinational. Assumes the group masks come from hps_pkg.
module hps_check_gen
    import hps_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  chk_o,
    output logic              word_par_o
);

    // One XOR-reduction tree per check group.
    for (genvar g = 0; g < CHK_W; g++) begin : g_grp
        localparam logic [DATA_W-1:0] MASK = group_mask(g);
        assign chk_o[g] = ^(data_i & MASK);
    end

    // Parity over the full word.
    assign word_par_o = ^data_i;

endmodule

// File: rtl/hps_parity_gate.sv
// Module: hps_parity_gate
// Applies odd/even polarity to the word parity and compares it with
// the externally supplied expected bit. Output 1 means mismatch.
// Assumes odd_sel_i = 1 selects odd parity.
module hps_parity_gate (
    input  logic word_par_i,
    input  logic odd_sel_i,
    input  logic exp_par_i,
    output logic gen_par_o
);

    // Polarity-corrected parity compared with the expected bit.
    always_comb begin
        gen_par_o = (word_par_i ^ odd_sel_i) ^ exp_par_i;
    end

endmodule

// File: rtl/hps_scan_cell.sv
// Module: hps_scan_cell
// One-bit parity register with enable, hold, shift and load. The
// priority is enable, then hold, then shift. Reset is synchronous and
// active-low. The stored bit is also the scan output.
module hps_scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic hold_i,
    input  logic shift_i,
    input  logic scan_i,
    input  logic d_i,
    output logic q_o
);

    logic nxt;

    // Next-state selection: keep, shift in, or capture parity.
    always_comb begin
        nxt = q_o;
        if (en_i && !hold_i) begin
            nxt = shift_i ? scan_i : d_i;
        end
    end

    // State register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else begin
            q_o <= nxt;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (q_o == 1'b0)); // R4
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && hold_i) |=> $stable(q_o)); // R5
    AST_SHIFT_TAKES_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !hold_i && shift_i) |=> (q_o == $past(scan_i))); // R6
    AST_LOAD_TAKES_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !hold_i && !shift_i) |=> (q_o == $past(d_i))); // R7
    AST_DISABLED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(q_o)); // R8

endmodule

// File: rtl/hamming_parity_scan.sv
// Module: hamming_parity_scan
// Top level. Combines the check-bit generator, the parity gate and the
// scannable error-flag register. The flag is offered in true and
// complement form, and the true form doubles as the scan output.
module hamming_parity_scan
    import hps_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              odd_sel_i,
    input  logic              exp_par_i,
    input  logic              en_i,
    input  logic              hold_i,
    input  logic              shift_i,
    input  logic              scan_i,
    output logic [CHK_W-1:0]  chk_o,
    output logic              word_par_o,
    output logic              gen_par_o,
    output logic              err_o,
    output logic              err_n_o
);

    logic wpar;
    logic gpar;
    logic flag;

    hps_check_gen u_chk (
        .data_i     (data_i),
        .chk_o      (chk_o),
        .word_par_o (wpar)
    );

    hps_parity_gate u_gate (
        .word_par_i (wpar),
        .odd_sel_i  (odd_sel_i),
        .exp_par_i  (exp_par_i),
        .gen_par_o  (gpar)
    );

    hps_scan_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .hold_i  (hold_i),
        .shift_i (shift_i),
        .scan_i  (scan_i),
        .d_i     (gpar),
        .q_o     (flag)
    );

    // Drive the parity and flag outputs in both polarities.
    always_comb begin
        word_par_o = wpar;
        gen_par_o  = gpar;
        err_o      = flag;
        err_n_o    = ~flag;
    end

endmodule

// File: tb/hamming_parity_scan_tb_top.sv
`timescale 1ns/1ps
module hamming_parity_scan_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] data;
    logic       odd_sel, exp_par, en, hold, shift, scan_in;

    logic [3:0] chk0, chk1, chk2;
    logic       wp0, wp1, wp2, gp0, gp1, gp2;
    logic       e0, e1, e2, en0, en1, en2;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    hamming_parity_scan dut_i (
        .clk(clk), .rst_n(rst_n), .data_i(data), .odd_sel_i(odd_sel),
        .exp_par_i(exp_par), .en_i(en), .hold_i(hold), .shift_i(shift),
        .scan_i(scan_in), .chk_o(chk0), .word_par_o(wp0), .gen_par_o(gp0),
        .err_o(e0), .err_n_o(en0));

    hamming_parity_scan dut1_i (
        .clk(clk), .rst_n(rst_n), .data_i(data), .odd_sel_i(odd_sel),
        .exp_par_i(exp_par), .en_i(en), .hold_i(hold), .shift_i(shift),
        .scan_i(e0), .chk_o(chk1), .word_par_o(wp1), .gen_par_o(gp1),
        .err_o(e1), .err_n_o(en1));

    hamming_parity_scan dut2_i (
        .clk(clk), .rst_n(rst_n), .data_i(data), .odd_sel_i(odd_sel),
        .exp_par_i(exp_par), .en_i(en), .hold_i(hold), .shift_i(shift),
        .scan_i(e1), .chk_o(chk2), .word_par_o(wp2), .gen_par_o(gp2),
        .err_o(e2), .err_n_o(en2));

    // Register vectors: {en, hold, shift, scan, data[7:0], q2, q1, q0}.
    // odd_sel = exp_par = 0, so the loaded value is the byte parity.
    localparam int NVEC = 12;
    localparam logic [14:0] VEC [NVEC] = '{
        {4'b1011, 8'h00, 3'b001},  // R6 shift 1 in
        {4'b1010, 8'h00, 3'b010},  // R9 ring moves
        {4'b1011, 8'h00, 3'b101},  // R6
        {4'b0010, 8'h00, 3'b101},  // R8 disabled shift ignored
        {4'b1110, 8'h00, 3'b101},  // R5 hold beats shift
        {4'b1000, 8'h01, 3'b111},  // R7 load parity 1
        {4'b1000, 8'h03, 3'b000},  // R7 load parity 0
        {4'b0000, 8'h01, 3'b000},  // R8 disabled load ignored
        {4'b1011, 8'h01, 3'b001},  // R6
        {4'b1011, 8'h01, 3'b011},  // R9
        {4'b1010, 8'h01, 3'b110},  // R9
        {4'b1100, 8'h01, 3'b110}   // R5 hold beats load
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_flags(input logic [2:0] exp_q, input string req);
        check({e2, e1, e0} == exp_q, req, {e2, e1, e0}, exp_q);
        check({en2, en1, en0} == ~exp_q, "R9 complement", {en2, en1, en0}, ~exp_q);
    endtask

    initial begin
        rst_n = 1'b0; data = '0; odd_sel = 0; exp_par = 0;
        en = 0; hold = 0; shift = 0; scan_in = 0;
        repeat (3) @(posedge clk);
        #1;
        check_flags(3'b000, "R4 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive combinational sweep against a bit-level model.
        for (int d = 0; d < 256; d++) begin
            for (int m = 0; m < 4; m++) begin
                logic [7:0] b;
                logic [3:0] ec;
                logic       ew, eg;
                b = d[7:0];
                @(negedge clk);
                data = b; odd_sel = m[0]; exp_par = m[1];
                ec[0] = b[1] ^ b[3] ^ b[5] ^ b[7];
                ec[1] = b[2] ^ b[3] ^ b[6] ^ b[7];
                ec[2] = b[4] ^ b[5] ^ b[6] ^ b[7];
                ec[3] = b[1] ^ b[2] ^ b[4] ^ b[7];
                ew = b[0] ^ b[1] ^ b[2] ^ b[3] ^ b[4] ^ b[5] ^ b[6] ^ b[7];
                eg = ew ^ m[0] ^ m[1];
                #1;
                check(chk0 == ec, "R1 check bits", chk0, ec);
                check(wp0 == ew, "R2 word parity", wp0, ew);
                check(gp0 == eg, "R3 gated parity", gp0, eg);
            end
        end
        // The sweep ran with en = 0, so the flags must still be clear (R8).
        check_flags(3'b000, "R8 sweep left flags");

        // Table-driven register and ring sequence.
        odd_sel = 0; exp_par = 0;
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            {en, hold, shift, scan_in} = VEC[i][14:11];
            data = VEC[i][10:3];
            @(posedge clk);
            #1;
            check_flags(VEC[i][2:0], $sformatf("R5-8 vector %0d", i));
        end

        // A load with odd polarity and a matching expected bit gives 0. Load 1 first.
        @(negedge clk);
        en = 1; hold = 0; shift = 0; data = 8'h00; odd_sel = 1; exp_par = 0;
        @(posedge clk); #1;
        check_flags(3'b111, "R7 odd load");
        @(negedge clk);
        exp_par = 1;
        @(posedge clk); #1;
        check_flags(3'b000, "R7 odd match");

        // Reset in mid-run clears a set flag.
        @(negedge clk);
        exp_par = 0;
        @(posedge clk); #1;
        check_flags(3'b111, "R7 preset");
        @(negedge clk);
        rst_n = 0; en = 0;
        @(posedge clk); #1;
        check_flags(3'b000, "R4 sync reset");
        @(negedge clk);
        rst_n = 1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule